// File: doc/BRIEF.md
# Spare Area Erased-Page Checker

This block sits beside a NAND page-read path and watches the spare area of a page as it streams past, one byte per accepted beat. It counts how many of the spare bytes are not the erased value 0xFF. At the page's final beat it combines that count with the transfer outcome and the two ECC result nibbles, one for the user data and one for the control bytes, and produces a per-page status word. A page counts as erased when fewer than two spare bytes differ from 0xFF, so a single flipped byte in a blank page still reads as erased.

The block also raises a flag that tells the consumer to hand back all-ones control bytes in place of the real ones, because the control ECC could not correct them. A second output keeps a 16-bit summary with one 4-bit nibble per bank. A multi-bank read sweep fills this word, starting at bank 0. The block does not decode ECC. It only packs the results that it receives.

Top module: `spare_erase_checker`

## Requirements
- R1: After reset, `result_valid` and `ctrl_subst` are 0, `status` is 0x000 and `bank_word` is 0x0000.
- R2: A beat is accepted on a clock edge where `in_valid` is 1. The beat that ends a page also has `in_last` set. The clock edge that accepts this final beat updates `status`, `ctrl_subst` and `bank_word`, and drives `result_valid` to 1 for exactly that one cycle. The outputs then hold until the next page ends.
- R3: Only the first 64 beats of a page are inspected, and each inspected byte not equal to 0xFF counts as a bad byte. Status bit 1 (erased) is 1 when `check_empty` is 1 and the page has fewer than 2 bad bytes. Otherwise it is 0.
- R4: When `check_empty` is 0 at the final beat, status bit 1 is 0 whatever the byte contents.
- R5: On a page without failure, status bits 7:4 equal `data_ecc`, bits 11:8 equal `ctrl_ecc`, and bits 3:2 are 0. `check_empty`, `xfer_fail`, `data_ecc`, `ctrl_ecc` and `bank_sel` are sampled only at the final beat.
- R6: On a page without failure, `ctrl_subst` equals bit 0 of `ctrl_ecc`. This bit means the control ECC result is uncorrectable.
- R7: A page fails when `xfer_fail` is 1 at the final beat, or when the page did not have exactly 64 beats. A failed page gives `status` = 0x001 and `ctrl_subst` = 0.
- R8: Cycles with `in_valid` low change nothing. Both counts restart from zero after every final beat.
- R9: At each page end, the nibble of `bank_word` at bits 4·`bank_sel`+3 down to 4·`bank_sel` is set to {ctrl ECC bit 0, data ECC bit 0, erased, fail}. On a failed page this nibble is 0b0001. If `bank_sel` is 0, the other nibbles are cleared. Otherwise the other nibbles keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Spare byte beat is valid |
| in_data | input | 8 | Spare byte |
| in_last | input | 1 | Final beat of the page |
| check_empty | input | 1 | Enables the erased-page decision |
| xfer_fail | input | 1 | Transfer reported a failure |
| data_ecc | input | 4 | User-data ECC result nibble |
| ctrl_ecc | input | 4 | Control-byte ECC result nibble |
| bank_sel | input | 2 | Bank the page came from |
| result_valid | output | 1 | One-cycle pulse for a new page result |
| status | output | 12 | Packed per-page status word |
| ctrl_subst | output | 1 | Replace the 12 control bytes with 0xFF |
| bank_word | output | 16 | Per-bank 4-bit summaries |

## Verification
The bench moves a single bad byte across all 64 spare positions and checks that each such page still reads as erased. It then checks pages with two bad bytes, which must not read as erased. A threshold off by one, or a count that skips an offset, would flip the erased bit at that offset. It sweeps every pair of ECC nibbles and places idle gaps filled with 0x00 inside pages. A design that misplaces a field, or that counts bytes on idle cycles, would show this in the status word. Pages of 1, 63 and 65 beats and asserted transfer failures check that a failure returns exactly 0x001. A page with many bad bytes, followed by a page with one bad byte, shows whether the count is cleared between pages. Out-of-order bank sweeps check that a result for bank 0 clears the other nibbles and that a result for any other bank leaves them alone.

// File: rtl/spare_chk_pkg.sv
package spare_chk_pkg;

   localparam int ECC_NIB_W  = 4;
   localparam int STATUS_W   = 12;
   localparam int BANK_NIB_W = 4;

   typedef struct packed {
      logic                 fail;
      logic                 erased;
      logic [ECC_NIB_W-1:0] d_ecc;
      logic [ECC_NIB_W-1:0] c_ecc;
   } page_res_t;

   // Status word layout: [11:8] control ECC, [7:4] data ECC, [3:2] zero,
   // [1] erased, [0] failure.
   function automatic logic [STATUS_W-1:0] pack_status(input page_res_t r);
      return {r.c_ecc, r.d_ecc, 2'b00, r.erased, r.fail};
   endfunction

   // Bank summary nibble: [3] control uncorrectable, [2] data uncorrectable,
   // [1] erased, [0] failure.
   function automatic logic [BANK_NIB_W-1:0] bank_nibble(input page_res_t r);
      return {r.c_ecc[0], r.d_ecc[0], r.erased, r.fail};
   endfunction

endpackage

// File: rtl/spare_beat_counter.sv
module spare_beat_counter #(
   parameter int                SPARE_BYTES = 64,
   parameter int                ERASE_LIMIT = 2,
   parameter int                BYTE_W      = 8,
   parameter logic [BYTE_W-1:0] FILL_VAL    = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_en,
   input  logic              beat_last,
   input  logic [BYTE_W-1:0] beat_data,
   output logic              len_ok,
   output logic              few_bad
);

   localparam int BCW = $clog2(SPARE_BYTES + 2);
   localparam int ECW = $clog2(ERASE_LIMIT + 1);
   localparam logic [BCW-1:0] FULL = BCW'(SPARE_BYTES);
   localparam logic [BCW-1:0] OVER = BCW'(SPARE_BYTES + 1);
   localparam logic [ECW-1:0] LIM  = ECW'(ERASE_LIMIT);

   logic [BCW-1:0] beat_cnt, beats_now;
   logic [ECW-1:0] bad_cnt, bad_now;
   logic           in_window;

   always_comb begin
      in_window = beat_cnt < FULL;
      beats_now = (beat_cnt == OVER) ? OVER : beat_cnt + 1'b1;
      if (in_window && (beat_data != FILL_VAL) && (bad_cnt != LIM))
         bad_now = bad_cnt + 1'b1;
      else
         bad_now = bad_cnt;
      len_ok  = beats_now == FULL;
      few_bad = bad_now < LIM;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_cnt <= '0;
         bad_cnt  <= '0;
      end else if (beat_en) begin
         if (beat_last) begin
            beat_cnt <= '0;
            bad_cnt  <= '0;
         end else begin
            beat_cnt <= beats_now;
            bad_cnt  <= bad_now;
         end
      end
   end

   a_r3_bad_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cnt <= LIM);

   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_en && beat_last) |=> (beat_cnt == '0 && bad_cnt == '0));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_en |=> ($stable(beat_cnt) && $stable(bad_cnt)));

endmodule

// File: rtl/spare_status_pack.sv
module spare_status_pack
   import spare_chk_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic                 xfer_fail,
   input  logic                 len_ok,
   input  logic                 few_bad,
   input  logic                 check_empty,
   input  logic [ECC_NIB_W-1:0] data_ecc,
   input  logic [ECC_NIB_W-1:0] ctrl_ecc,
   output page_res_t            res_now,
   output logic                 result_valid,
   output logic [STATUS_W-1:0]  status,
   output logic                 ctrl_subst
);

   always_comb begin
      res_now.fail   = xfer_fail | ~len_ok;
      res_now.erased = ~res_now.fail & check_empty & few_bad;
      res_now.d_ecc  = res_now.fail ? '0 : data_ecc;
      res_now.c_ecc  = res_now.fail ? '0 : ctrl_ecc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_valid <= 1'b0;
         status       <= '0;
         ctrl_subst   <= 1'b0;
      end else begin
         result_valid <= capture;
         if (capture) begin
            status     <= pack_status(res_now);
            ctrl_subst <= res_now.c_ecc[0];
         end
      end
   end

   a_r7_fail_alone: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] |-> (status[STATUS_W-1:1] == '0 && !ctrl_subst));

   a_r6_subst_matches: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_subst |-> status[8]);

   a_r5_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status[3:2] == 2'b00);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ($stable(status) && $stable(ctrl_subst)));

endmodule

// File: rtl/bank_word_accum.sv
module bank_word_accum
   import spare_chk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   localparam int BSW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int WW  = BANK_NIB_W * NUM_BANKS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd,
   input  logic [BSW-1:0]        bank_sel,
   input  logic [BANK_NIB_W-1:0] nib_in,
   output logic [WW-1:0]         word
);

   logic sweep_start;
   assign sweep_start = bank_sel == '0;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BANK_NIB_W-1:0] nib_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            nib_q <= '0;
         else if (upd) begin
            if (bank_sel == BSW'(b))
               nib_q <= nib_in;
            else if (sweep_start)
               nib_q <= '0;
         end
      end
      assign word[b*BANK_NIB_W +: BANK_NIB_W] = nib_q;
   end

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(word));

endmodule

// File: rtl/spare_erase_checker.sv
module spare_erase_checker
   import spare_chk_pkg::*;
#(
   parameter int SPARE_BYTES = 64,
   parameter int ERASE_LIMIT = 2,
   parameter int NUM_BANKS   = 4,
   parameter int BYTE_W      = 8,
   localparam int BSW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int WW  = BANK_NIB_W * NUM_BANKS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [BYTE_W-1:0]    in_data,
   input  logic                 in_last,
   input  logic                 check_empty,
   input  logic                 xfer_fail,
   input  logic [ECC_NIB_W-1:0] data_ecc,
   input  logic [ECC_NIB_W-1:0] ctrl_ecc,
   input  logic [BSW-1:0]       bank_sel,
   output logic                 result_valid,
   output logic [STATUS_W-1:0]  status,
   output logic                 ctrl_subst,
   output logic [WW-1:0]        bank_word
);

   if (SPARE_BYTES < 1) begin : g_bad_len
      $error("SPARE_BYTES must be at least 1");
   end
   if (ERASE_LIMIT < 1 || ERASE_LIMIT > SPARE_BYTES) begin : g_bad_lim
      $error("ERASE_LIMIT must lie in 1..SPARE_BYTES");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("NUM_BANKS must be at least 1");
   end

   logic      capture, len_ok, few_bad;
   page_res_t res_now;

   assign capture = in_valid & in_last;

   spare_beat_counter #(
      .SPARE_BYTES(SPARE_BYTES),
      .ERASE_LIMIT(ERASE_LIMIT),
      .BYTE_W     (BYTE_W),
      .FILL_VAL   ({BYTE_W{1'b1}})
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .beat_en  (in_valid),
      .beat_last(in_last),
      .beat_data(in_data),
      .len_ok   (len_ok),
      .few_bad  (few_bad)
   );

   spare_status_pack u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (capture),
      .xfer_fail   (xfer_fail),
      .len_ok      (len_ok),
      .few_bad     (few_bad),
      .check_empty (check_empty),
      .data_ecc    (data_ecc),
      .ctrl_ecc    (ctrl_ecc),
      .res_now     (res_now),
      .result_valid(result_valid),
      .status      (status),
      .ctrl_subst  (ctrl_subst)
   );

   bank_word_accum #(.NUM_BANKS(NUM_BANKS)) u_banks (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (capture),
      .bank_sel(bank_sel),
      .nib_in  (bank_nibble(res_now)),
      .word    (bank_word)
   );

   a_r2_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $past(in_valid && in_last));

   a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> result_valid);

   a_r4_no_erase: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last && !check_empty) |=> !status[1]);

endmodule

// File: tb/spare_erase_checker_tb.sv
module spare_erase_checker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_last = 1'b0;
   logic        check_empty = 1'b0;
   logic        xfer_fail = 1'b0;
   logic [3:0]  data_ecc = 4'h0;
   logic [3:0]  ctrl_ecc = 4'h0;
   logic [1:0]  bank_sel = 2'd0;
   logic        result_valid;
   logic [11:0] status;
   logic        ctrl_subst;
   logic [15:0] bank_word;

   int checks = 0;
   int errors = 0;
   logic [15:0] bw_m = 16'h0;

   always #4 clk = ~clk;

   spare_erase_checker u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .check_empty(check_empty), .xfer_fail(xfer_fail),
      .data_ecc(data_ecc), .ctrl_ecc(ctrl_ecc), .bank_sel(bank_sel),
      .result_valid(result_valid), .status(status), .ctrl_subst(ctrl_subst),
      .bank_word(bank_word)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Sends one page. mask marks bad bytes among the first 64 beats.
   task automatic run_page(input int nb, input logic [63:0] mask, input logic ce,
                           input logic xf, input logic [3:0] de, input logic [3:0] cee,
                           input int bk, input bit gaps, input string tag);
      int   nbad;
      logic fl, er;
      logic [11:0] st_e;
      logic [3:0]  nib;
      nbad = 0;
      for (int i = 0; i < nb; i++) begin
         if (gaps && (i % 5 == 2)) begin
            @(negedge clk);
            in_valid = 1'b0; in_data = 8'h00; in_last = 1'b1;
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_last  = (i == nb - 1);
         if (i < 64) begin
            in_data = mask[i] ? {6'(i), 2'b00} : 8'hFF;
            if (mask[i]) nbad++;
         end else
            in_data = 8'h12;
         if (i == nb - 1) begin
            check_empty = ce; xfer_fail = xf; data_ecc = de; ctrl_ecc = cee;
            bank_sel = 2'(bk);
         end else begin
            check_empty = ~ce; xfer_fail = ~xf; data_ecc = ~de; ctrl_ecc = ~cee;
            bank_sel = 2'(bk + 1);
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
      fl   = xf || (nb != 64);
      er   = !fl && ce && (nbad < 2);
      st_e = fl ? 12'h001 : {cee, de, 2'b00, er, 1'b0};
      nib  = fl ? 4'b0001 : {cee[0], de[0], er, 1'b0};
      if (bk == 0) bw_m = 16'h0;
      bw_m[4*bk +: 4] = nib;
      chk("R2 result_valid high after last beat", {31'd0, result_valid}, 32'd1);
      chk(tag, {20'd0, status}, {20'd0, st_e});
      chk("R6 ctrl_subst", {31'd0, ctrl_subst}, {31'd0, !fl && cee[0]});
      chk("R9 bank_word", {16'd0, bank_word}, {16'd0, bw_m});
      @(negedge clk);
      chk("R2 result_valid single pulse", {31'd0, result_valid}, 32'd0);
      chk("R2 status held", {20'd0, status}, {20'd0, st_e});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 result_valid reset", {31'd0, result_valid}, 32'd0);
      chk("R1 status reset", {20'd0, status}, 32'd0);
      chk("R1 ctrl_subst reset", {31'd0, ctrl_subst}, 32'd0);
      chk("R1 bank_word reset", {16'd0, bank_word}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: clean page, one bad byte everywhere, two bad bytes, all bad
      run_page(64, 64'h0, 1'b1, 1'b0, 4'h0, 4'h0, 0, 1'b0, "R3 clean page erased");
      for (int p = 0; p < 64; p++)
         run_page(64, 64'h1 << p, 1'b1, 1'b0, 4'h0, 4'h0, 0, 1'b0, "R3 one bad byte erased");
      for (int p = 0; p < 64; p += 3)
         run_page(64, (64'h1 << p) | (64'h1 << ((p + 17) % 64)), 1'b1, 1'b0,
                  4'h0, 4'h0, 1, 1'b0, "R3 two bad bytes not erased");
      run_page(64, ~64'h0, 1'b1, 1'b0, 4'h0, 4'h0, 2, 1'b0, "R3 all bad");

      // R4: check disabled
      run_page(64, 64'h0, 1'b0, 1'b0, 4'h0, 4'h0, 0, 1'b0, "R4 disabled clean");
      run_page(64, 64'h8000, 1'b0, 1'b0, 4'h3, 4'h0, 3, 1'b0, "R4 disabled one bad");

      // R5: every ECC nibble pair
      for (int d = 0; d < 16; d++)
         for (int c = 0; c < 16; c++)
            run_page(64, (d % 3 == 0) ? 64'h0 : 64'h11, c[0] ^ d[1], 1'b0,
                     4'(d), 4'(c), (d + c) % 4, 1'b0, "R5 ecc fields");

      // R7: failures
      run_page(64, 64'h0, 1'b1, 1'b1, 4'hF, 4'hF, 1, 1'b0, "R7 transfer fail");
      run_page(63, 64'h0, 1'b1, 1'b0, 4'h5, 4'h3, 2, 1'b0, "R7 short page");
      run_page(65, 64'h0, 1'b1, 1'b0, 4'hA, 4'h1, 3, 1'b0, "R7 long page");
      run_page(1,  64'h0, 1'b1, 1'b0, 4'h1, 4'h1, 0, 1'b0, "R7 one beat page");

      // R8: idle gaps with 0x00 and last high, count restart
      run_page(64, 64'h0, 1'b1, 1'b0, 4'h2, 4'h0, 0, 1'b1, "R8 gaps clean");
      run_page(64, 64'h400, 1'b1, 1'b0, 4'h0, 4'h4, 1, 1'b1, "R8 gaps one bad");
      run_page(64, 64'hFFFF_0000_0000_FFFF, 1'b1, 1'b0, 4'h0, 4'h0, 2, 1'b0, "R8 many bad");
      run_page(64, 64'h1, 1'b1, 1'b0, 4'h0, 4'h0, 2, 1'b0, "R8 restart after bad page");

      // R9: bank sweeps in order and out of order
      run_page(64, 64'h0, 1'b1, 1'b0, 4'h1, 4'h1, 0, 1'b0, "R9 bank0");
      run_page(64, 64'h3, 1'b1, 1'b0, 4'h0, 4'h1, 1, 1'b0, "R9 bank1");
      run_page(64, 64'h0, 1'b1, 1'b1, 4'h1, 4'h1, 2, 1'b0, "R9 bank2 fail");
      run_page(64, 64'h0, 1'b0, 1'b0, 4'h1, 4'h0, 3, 1'b0, "R9 bank3");
      run_page(64, 64'h0, 1'b1, 1'b0, 4'h0, 4'h0, 2, 1'b0, "R9 bank2 rewrite");
      run_page(64, 64'h0, 1'b0, 1'b0, 4'h0, 4'h0, 0, 1'b0, "R9 bank0 clears");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule